// File: doc/BRIEF.md
# Transactional Read/Write Set Tracker

This per-core unit keeps the bookkeeping for one hardware transaction at a time. After a begin strobe, every load records its cache-line number in a read bitmap. Every store records its line in a write bitmap, and the store itself is held back from memory. When other cores finish their transactions, their committed write sets arrive as line bitmaps. If any of those lines is also in the local read bitmap, the transaction is doomed. The unit then raises a one-cycle abort, lists the speculatively written lines so they can be discarded, and empties both bitmaps so software can restart the transaction from its first instruction.

An end strobe turns the running transaction into a pending commit. The local write bitmap is offered on a valid/ready channel and held there until the commit arbiter grants it. One cycle after the grant, both bitmaps are empty and the unit is idle again.

The remote write-set input is a valid/ready stream that never applies back-pressure: `rws_ready` is always high, so every beat with `rws_valid` high is consumed in that cycle. On the commit channel the tracker is the producer. Once `cmt_valid` rises, it and `cmt_lines` stay unchanged until a cycle with `cmt_ready` high. The one exception is an abort, which withdraws the offer.

Top module: `txn_set_tracker`

## Requirements
- R1: While a transaction is running, a store with `st_valid` high sets bit `st_line` of the write bitmap. A store in the same cycle as the end strobe is included.
- R2: While a transaction is running or its commit is pending, a remote beat whose mask shares a bit with the read bitmap raises `abort_pulse` on the next cycle.
- R3: A load in the same cycle as a remote beat is already part of the read bitmap used in that cycle's comparison.
- R4: `abort_pulse` lasts exactly one cycle. In that cycle `inv_lines` equals the write bitmap, bit n standing for line n; in every other cycle `inv_lines` is zero. Both bitmaps are empty afterwards.
- R5: With no transaction running, loads, stores and remote beats are ignored: nothing is recorded and no abort occurs.
- R6: An end strobe during a running transaction raises `cmt_valid` on the next cycle, with `cmt_lines` equal to the write bitmap. Both stay stable until `cmt_ready` is seen.
- R7: `cmt_valid` falls in the cycle after the grant. Both bitmaps are cleared one cycle after the grant. A remote beat in that clearing cycle does not abort.
- R8: An abort while a commit is pending drops `cmt_valid`. If a grant arrives in the same cycle as the conflict, the abort wins.
- R9: `rws_ready` is always high, so a remote mask is consumed in every cycle in which `rws_valid` is high.
- R10: After reset, `abort_pulse`, `inv_lines`, `cmt_valid` and `cmt_lines` are zero and no transaction is running.
- R11: A remote mask that overlaps only the write bitmap, and not the read bitmap, does not abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_begin | input | 1 | Start a transaction (honoured only when idle) |
| txn_end | input | 1 | End the running transaction and request commit |
| ld_valid | input | 1 | Load event |
| ld_line | input | 6 | Line number of the load |
| st_valid | input | 1 | Store event |
| st_line | input | 6 | Line number of the store |
| rws_valid | input | 1 | Remote committed write set present |
| rws_ready | output | 1 | Always high; remote beats are never stalled |
| rws_mask | input | 64 | Remote committed write set, bit n = line n |
| cmt_valid | output | 1 | Commit request pending |
| cmt_ready | input | 1 | Commit grant |
| cmt_lines | output | 64 | Local write set published with the request |
| abort_pulse | output | 1 | One-cycle abort indication |
| inv_lines | output | 64 | Lines to discard, valid with `abort_pulse` |

## Verification
The assertions take for granted that the commit arbiter drives `cmt_ready` only when the grant can apply, and that an abort is the only event that may withdraw an offered commit. The checks on the published set therefore accept an abort as the single alternative to a stable offer. The checker also assumes that `rws_valid` is low while reset is applied, because the abort check looks one cycle back at it. The stimulus holds all strobes low during reset. It raises `cmt_ready` only from the bench's own view of a pending request, and it steers conflicts into the pending-commit window on purpose, including one in the same cycle as a grant.

// File: rtl/txn_track_pkg.sv
package txn_track_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_RUN    = 2'd1,
    PH_COMMIT = 2'd2,
    PH_DRAIN  = 2'd3
  } txn_phase_e;
endpackage

// File: rtl/txn_line_bitmap.sv
module txn_line_bitmap #(
  parameter int LINES = 64,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx,
  input  logic             clr,
  output logic [LINES-1:0] view
);
  // view = stored bits plus the line being marked this cycle
  logic [LINES-1:0] bits_q;

  for (genvar i = 0; i < LINES; i++) begin : g_bit
    logic hit;
    assign hit     = mark_en && (mark_idx == IDX_W'(i));
    assign view[i] = bits_q[i] | hit;
    always_ff @(posedge clk) begin
      if (!rst_n)   bits_q[i] <= 1'b0;
      else if (clr) bits_q[i] <= 1'b0;
      else          bits_q[i] <= view[i];
    end
  end
endmodule

// File: rtl/txn_conflict_check.sv
module txn_conflict_check #(
  parameter int LINES = 64
) (
  input  logic             check_en,
  input  logic             remote_valid,
  input  logic [LINES-1:0] remote_mask,
  input  logic [LINES-1:0] read_view,
  output logic             hit
);
  logic [LINES-1:0] overlap;
  assign overlap = remote_mask & read_view;
  assign hit     = check_en && remote_valid && (|overlap);
endmodule

// File: rtl/txn_phase_ctrl.sv
module txn_phase_ctrl
  import txn_track_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txn_begin,
  input  logic       txn_end,
  input  logic       hit,
  input  logic       grant,
  output txn_phase_e phase,
  output logic       track_en,
  output logic       check_en,
  output logic       abort_fire,
  output logic       load_commit,
  output logic       clr_sets
);
  txn_phase_e phase_nx;

  assign track_en = (phase == PH_RUN);
  assign check_en = (phase == PH_RUN) || (phase == PH_COMMIT);

  always_comb begin
    phase_nx    = phase;
    abort_fire  = 1'b0;
    load_commit = 1'b0;
    clr_sets    = 1'b0;
    if (hit) begin
      // abort outranks end strobe and grant
      abort_fire = 1'b1;
      clr_sets   = 1'b1;
      phase_nx   = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE:   if (txn_begin) phase_nx = PH_RUN;
        PH_RUN:    if (txn_end) begin
                     phase_nx    = PH_COMMIT;
                     load_commit = 1'b1;
                   end
        PH_COMMIT: if (grant) phase_nx = PH_DRAIN;
        PH_DRAIN:  begin
                     clr_sets = 1'b1;
                     phase_nx = PH_IDLE;
                   end
        default:   phase_nx = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end
endmodule

// File: rtl/txn_set_tracker.sv
module txn_set_tracker
  import txn_track_pkg::*;
#(
  parameter int LINES = 64,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txn_begin,
  input  logic             txn_end,
  input  logic             ld_valid,
  input  logic [IDX_W-1:0] ld_line,
  input  logic             st_valid,
  input  logic [IDX_W-1:0] st_line,
  input  logic             rws_valid,
  output logic             rws_ready,
  input  logic [LINES-1:0] rws_mask,
  output logic             cmt_valid,
  input  logic             cmt_ready,
  output logic [LINES-1:0] cmt_lines,
  output logic             abort_pulse,
  output logic [LINES-1:0] inv_lines
);
  txn_phase_e       phase;
  logic             track_en, check_en, abort_fire, load_commit, clr_sets, hit;
  logic [LINES-1:0] rd_view, wr_view;

  assign rws_ready = 1'b1;

  txn_phase_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .txn_begin(txn_begin), .txn_end(txn_end),
    .hit(hit), .grant(cmt_ready), .phase(phase), .track_en(track_en),
    .check_en(check_en), .abort_fire(abort_fire), .load_commit(load_commit),
    .clr_sets(clr_sets)
  );

  txn_line_bitmap #(.LINES(LINES)) u_rd (
    .clk(clk), .rst_n(rst_n), .mark_en(track_en && ld_valid),
    .mark_idx(ld_line), .clr(clr_sets), .view(rd_view)
  );

  txn_line_bitmap #(.LINES(LINES)) u_wr (
    .clk(clk), .rst_n(rst_n), .mark_en(track_en && st_valid),
    .mark_idx(st_line), .clr(clr_sets), .view(wr_view)
  );

  txn_conflict_check #(.LINES(LINES)) u_cc (
    .check_en(check_en), .remote_valid(rws_valid), .remote_mask(rws_mask),
    .read_view(rd_view), .hit(hit)
  );

  assign cmt_valid = (phase == PH_COMMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abort_pulse <= 1'b0;
      inv_lines   <= '0;
      cmt_lines   <= '0;
    end else begin
      abort_pulse <= abort_fire;
      inv_lines   <= abort_fire ? wr_view : '0;
      if (abort_fire || (cmt_valid && cmt_ready)) cmt_lines <= '0;
      else if (load_commit)                       cmt_lines <= wr_view;
    end
  end
endmodule

// File: rtl/txn_set_tracker_chk.sv
module txn_set_tracker_chk #(
  parameter int LINES = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rws_valid,
  input logic             cmt_valid,
  input logic             cmt_ready,
  input logic [LINES-1:0] cmt_lines,
  input logic             abort_pulse,
  input logic [LINES-1:0] inv_lines
);
  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse); // R4
  AST_INV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_pulse |-> (inv_lines == '0)); // R4
  AST_ABORT_NEEDS_REMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> $past(rws_valid)); // R2
  AST_CMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && !cmt_ready) |=> ((cmt_valid && $stable(cmt_lines)) || abort_pulse)); // R6
  AST_CMT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && cmt_ready) |=> !cmt_valid); // R7
  AST_ABORT_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> !cmt_valid); // R8
endmodule

bind txn_set_tracker txn_set_tracker_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rws_valid(rws_valid), .cmt_valid(cmt_valid),
  .cmt_ready(cmt_ready), .cmt_lines(cmt_lines), .abort_pulse(abort_pulse),
  .inv_lines(inv_lines)
);

// File: tb/txn_set_tracker_test.sv
`timescale 1ns/1ps
module txn_set_tracker_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic txn_begin = 0, txn_end = 0, ld_valid = 0, st_valid = 0, rws_valid = 0, cmt_ready = 0;
  logic [5:0] ld_line = 0, st_line = 0;
  logic [63:0] rws_mask = 0;
  logic rws_ready, cmt_valid, abort_pulse;
  logic [63:0] cmt_lines, inv_lines;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference state: 0 idle, 1 running, 2 commit pending, 3 clearing
  int m_ph = 0;
  bit [63:0] m_rd = 0, m_wr = 0, m_inv = 0, m_cl = 0;
  bit m_ab = 0, m_cv = 0;

  always #2.5 clk = ~clk;

  txn_set_tracker uut (
    .clk(clk), .rst_n(rst_n), .txn_begin(txn_begin), .txn_end(txn_end),
    .ld_valid(ld_valid), .ld_line(ld_line), .st_valid(st_valid), .st_line(st_line),
    .rws_valid(rws_valid), .rws_ready(rws_ready), .rws_mask(rws_mask),
    .cmt_valid(cmt_valid), .cmt_ready(cmt_ready), .cmt_lines(cmt_lines),
    .abort_pulse(abort_pulse), .inv_lines(inv_lines)
  );

  task automatic compare(input string tag);
    checks++;
    if (abort_pulse !== m_ab || inv_lines !== m_inv || cmt_valid !== m_cv ||
        cmt_lines !== m_cl || rws_ready !== 1'b1) begin
      failures++;
      $display("FAIL %s abort=%0b/%0b inv=%h/%h cvalid=%0b/%0b clines=%h/%h ready=%0b/1",
               tag, abort_pulse, m_ab, inv_lines, m_inv, cmt_valid, m_cv,
               cmt_lines, m_cl, rws_ready);
    end
  endtask

  task automatic step(input string tag, input bit b, input bit e,
                      input bit lv, input int li, input bit sv, input int si,
                      input bit rv, input bit [63:0] rm, input bit cr);
    bit [63:0] erd, ewr;
    bit running, hit;
    txn_begin = b; txn_end = e; ld_valid = lv; ld_line = 6'(li);
    st_valid = sv; st_line = 6'(si); rws_valid = rv; rws_mask = rm; cmt_ready = cr;
    running = (m_ph == 1);
    erd = m_rd; ewr = m_wr;
    if (running && lv) erd[li] = 1'b1;
    if (running && sv) ewr[si] = 1'b1;
    hit = (m_ph == 1 || m_ph == 2) && rv && ((rm & erd) != 0);
    m_ab = hit; m_inv = hit ? ewr : 64'd0;
    if (hit) begin
      m_rd = 0; m_wr = 0; m_ph = 0; m_cv = 0; m_cl = 0;
    end else begin
      case (m_ph)
        0: if (b) m_ph = 1;
        1: begin
             m_rd = erd; m_wr = ewr;
             if (e) begin m_ph = 2; m_cv = 1; m_cl = ewr; end
           end
        2: if (cr) begin m_ph = 3; m_cv = 0; m_cl = 0; end
        default: begin m_rd = 0; m_wr = 0; m_ph = 0; end
      endcase
    end
    @(posedge clk); #1;
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 64'd0, 0);
  endtask

  function automatic bit [63:0] bit_of(input int n);
    return 64'd1 << n;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1; compare("R10 reset");
    rst_n = 1'b1;
    idle("R10 idle");

    // R1 / R6 / R7: stores, end with a same-cycle store, held commit
    step("R1 begin", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R1 store", 0, 0, 1, 4, 1, 3, 0, 0, 0);
    step("R1 store", 0, 0, 0, 0, 1, 10, 0, 0, 0);
    step("R1 end+store", 0, 1, 0, 0, 1, 63, 0, 0, 0);
    step("R6 hold", 0, 0, 0, 0, 1, 20, 0, 0, 0);
    step("R6 hold", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R6 hold", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R7 grant", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R7 clear cycle remote", 0, 0, 0, 0, 0, 0, 1, bit_of(4), 0);
    idle("R7 idle");

    // R2 / R4: load then remote conflict
    step("R2 begin", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2 load", 0, 0, 1, 5, 1, 33, 0, 0, 0);
    step("R2 remote", 0, 0, 0, 0, 0, 0, 1, bit_of(5) | bit_of(40), 0);
    idle("R4 single pulse");
    // R4: sets empty after abort
    step("R4 begin", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R4 old line", 0, 0, 0, 0, 0, 0, 1, bit_of(5), 0);
    step("R4 end", 0, 1, 0, 0, 0, 0, 0, 0, 0);
    step("R4 grant", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle("R4 drain");

    // R3: same-cycle load and remote
    step("R3 begin", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R3 store", 0, 0, 0, 0, 1, 8, 0, 0, 0);
    step("R3 load+remote", 0, 0, 1, 7, 0, 0, 1, bit_of(7), 0);
    idle("R3 after");

    // R11: write-only overlap
    step("R11 begin", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R11 store", 0, 0, 0, 0, 1, 9, 0, 0, 0);
    step("R11 remote", 0, 0, 0, 0, 0, 0, 1, bit_of(9), 0);
    step("R11 end", 0, 1, 0, 0, 0, 0, 0, 0, 0);
    step("R11 grant", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle("R11 drain");

    // R5: activity while idle is ignored
    step("R5 idle access", 0, 0, 1, 12, 1, 12, 1, bit_of(12), 0);
    step("R5 begin", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R5 remote", 0, 0, 0, 0, 0, 0, 1, bit_of(12), 0);
    step("R5 end", 0, 1, 0, 0, 0, 0, 0, 0, 0);
    step("R5 grant", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle("R5 drain");

    // R8: conflict during pending commit, same cycle as grant
    step("R8 begin", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R8 access", 0, 0, 1, 20, 1, 21, 0, 0, 0);
    step("R8 end", 0, 1, 0, 0, 0, 0, 0, 0, 0);
    step("R8 pending", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R8 abort beats grant", 0, 0, 0, 0, 0, 0, 1, bit_of(20), 1);
    idle("R8 after");

    // R9 / R2: pseudo-random traffic
    begin
      int unsigned s = 32'h1234_5678;
      for (int k = 0; k < 400; k++) begin
        bit b, e, lv, sv, rv, cr;
        int li, si;
        s = s * 1664525 + 1013904223; b  = (s[7:4] < 6);
        s = s * 1664525 + 1013904223; e  = (s[7:4] < 3);
        s = s * 1664525 + 1013904223; lv = s[8]; li = int'(s[13:10]);
        s = s * 1664525 + 1013904223; sv = s[8]; si = int'(s[13:10]) + 48;
        s = s * 1664525 + 1013904223; rv = (s[7:4] < 4);
        s = s * 1664525 + 1013904223; cr = (m_ph == 2) && s[9];
        step("R9 random", b, e, lv, li, sv, si, rv, bit_of(int'(s[15:12])), cr);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule